// File: doc/BRIEF.md
# Instruction Decode and Operand Fetch Stage

This block is the second stage of a five-stage in-order integer pipeline. A fetched instruction word and its PC are captured in a one-entry pipeline register under a valid/ready handshake. The held word is decoded into control bundles for the later stages: writeback, branch, ALU, memory and CSR. The decode also flags any encoding the stage does not support.

Both source operands are resolved in the same cycle. Each one comes from the newest in-flight producer that targets the same register, and otherwise from an external register file read port. When the execute stage holds a load or CSR instruction whose result a source needs, the stage stalls. A redirect from later in the pipeline discards whatever the stage holds.

Top module: `dec_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 whenever the stage is empty, when its entry leaves in this cycle (`out_valid && out_ready`), or when a redirect is present. An instruction accepted at a clock edge appears on `out_pc`/`out_inst` with `out_valid` right after that edge, which sustains one instruction per cycle.
- R3: While `out_valid` is 1 and `out_ready` is 0, the entry stays, with `out_pc` and `out_inst` unchanged.
- R4: Decode encodings. `out_wb_sel` is 0 for ALU, 1 for a load, 2 for a CSR and 3 for a link (JAL/JALR). `out_mem_op` is 0 for none, 1 for a load and 2 for a store, and `out_mem_fn` is funct3. `out_csr_op` is funct3 for a CSR access (0 otherwise) and `out_csr_addr` is bits 31:20. `out_alu_op` is {bit 30, funct3} for register-register operations and for immediate right shifts, and {0, funct3} otherwise.
- R5: Supported opcodes are LUI, AUIPC, JAL, JALR, conditional branch, load, store, OP-IMM, OP, and SYSTEM with funct3[1:0] not 0. Any other word gives `out_illegal`=1 and `out_wb_en`=0 and is still passed downstream.
- R6: Immediates are sign-extended per format. For OP-IMM, load and store, `out_alu_a` is rs1 and `out_alu_b` is the immediate. For LUI, `out_alu_a` is 0 and `out_alu_b` is the U immediate. For OP, `out_alu_b` is rs2. `out_br_kind` is 0 for none, 1 for JAL, 2 for JALR and 3 for a conditional branch, and `out_br_cond` is funct3. The base is the PC for JAL and conditional branches and the rs1 value for JALR. The offset is the format immediate.
- R7: Each source value is taken from the execute bypass if it matches. Otherwise it comes from the memory bypass, then from the writeback bypass, and last from the register file data.
- R8: The source field 0 always yields the value 0. It never takes a bypass and never causes a stall.
- R9: The stage stalls when `exe_ldcsr_valid` is 1 and `exe_ldcsr_addr` is non-zero and equals the rs1 field (bits 19:15) or the rs2 field (bits 24:20). During a stall `out_valid` is 0 and `in_ready` is 0, and the payload and `rf_raddr1`/`rf_raddr2` stay stable. Output resumes once the hazard clears.
- R10: When `redirect_valid` is 1, `out_valid` is 0 in that cycle and the held entry is discarded. An instruction offered in that cycle is dropped, so the stage is empty afterwards.
- R11: A redirect during a stall empties the stage, so no output appears after the hazard later clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetched instruction offered |
| in_ready | output | 1 | Stage accepts at this edge |
| in_pc | input | XLEN | PC of offered instruction |
| in_inst | input | 32 | Offered instruction word |
| redirect_valid | input | 1 | Discard the stage contents |
| exe_byp_valid | input | 1 | Execute stage result available |
| exe_byp_addr | input | 5 | Execute stage destination |
| exe_byp_data | input | XLEN | Execute stage result |
| mem_byp_valid | input | 1 | Memory stage result available |
| mem_byp_addr | input | 5 | Memory stage destination |
| mem_byp_data | input | XLEN | Memory stage result |
| wb_byp_valid | input | 1 | Writeback stage result available |
| wb_byp_addr | input | 5 | Writeback stage destination |
| wb_byp_data | input | XLEN | Writeback stage result |
| exe_ldcsr_valid | input | 1 | Execute holds a load or CSR instruction |
| exe_ldcsr_addr | input | 5 | Its destination register |
| rf_raddr1 | output | 5 | Register file read index, first source |
| rf_raddr2 | output | 5 | Register file read index, second source |
| rf_rdata1 | input | XLEN | Register file data, first source |
| rf_rdata2 | input | XLEN | Register file data, second source |
| out_valid | output | 1 | Decoded instruction available |
| out_ready | input | 1 | Execute stage accepts |
| out_pc | output | XLEN | Instruction PC |
| out_inst | output | 32 | Raw instruction word |
| out_illegal | output | 1 | Unsupported encoding |
| out_wb_en | output | 1 | Writes a register |
| out_wb_addr | output | 5 | Destination register |
| out_wb_sel | output | 2 | Result source selector |
| out_br_kind | output | 2 | Branch kind |
| out_br_cond | output | 3 | Branch condition |
| out_br_base | output | XLEN | Branch target base |
| out_br_off | output | XLEN | Branch target offset |
| out_alu_op | output | 4 | ALU operation |
| out_alu_a | output | XLEN | ALU first operand |
| out_alu_b | output | XLEN | ALU second operand |
| out_mem_op | output | 2 | Memory access kind |
| out_mem_fn | output | 3 | Memory access size/sign |
| out_csr_op | output | 3 | CSR operation |
| out_csr_addr | output | 12 | CSR address |
| out_rs1_val | output | XLEN | Resolved first source value |
| out_rs2_val | output | XLEN | Resolved second source value |

## Verification
The bench builds the stage with XLEN=32, the default. At that width the sign bit of every immediate format sits at bit 31, so negative branch, store and I-type offsets show their full sign extension. Full-width bypass values can also be told apart from register file values. All three bypass sources are driven at once with distinct data, which exposes the priority order. The register index 0 is exercised through both the bypass and the stall comparators.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [1:0] WB_ALU  = 2'd0;
  localparam logic [1:0] WB_MEM  = 2'd1;
  localparam logic [1:0] WB_CSR  = 2'd2;
  localparam logic [1:0] WB_LINK = 2'd3;

  localparam logic [1:0] BR_NONE = 2'd0;
  localparam logic [1:0] BR_JAL  = 2'd1;
  localparam logic [1:0] BR_JALR = 2'd2;
  localparam logic [1:0] BR_COND = 2'd3;

  localparam logic [1:0] MEM_NONE  = 2'd0;
  localparam logic [1:0] MEM_LOAD  = 2'd1;
  localparam logic [1:0] MEM_STORE = 2'd2;
endpackage

// File: rtl/dec_inreg.sv
module dec_inreg #(
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [XLEN-1:0]          in_pc,
  input  logic [dec_pkg::ILEN-1:0] in_inst,
  input  logic                     flush_i,
  input  logic                     take_i,
  output logic                     valid_o,
  output logic [XLEN-1:0]          pc_o,
  output logic [dec_pkg::ILEN-1:0] inst_o
);
  logic                     v_q, v_d, load;
  logic [XLEN-1:0]          pc_q;
  logic [dec_pkg::ILEN-1:0] inst_q;

  always_comb begin
    in_ready = !v_q || take_i || flush_i;
    load     = in_valid && in_ready && !flush_i;
    if (load)                  v_d = 1'b1;
    else if (take_i || flush_i) v_d = 1'b0;
    else                       v_d = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      inst_q <= '0;
    end else if (load) begin
      pc_q   <= in_pc;
      inst_q <= in_inst;
    end
  end

  assign valid_o = v_q;
  assign pc_o    = pc_q;
  assign inst_o  = inst_q;

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> in_ready); // R2
  AST_ACCEPT_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (v_q && inst_q == $past(in_inst) && pc_q == $past(in_pc))); // R2
  AST_FLUSH_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !v_q); // R10
endmodule

// File: rtl/dec_operand.sv
module dec_operand #(
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [dec_pkg::RAW-1:0] src_i,
  input  logic [XLEN-1:0]         rf_data_i,
  input  logic                    exe_v_i,
  input  logic [dec_pkg::RAW-1:0] exe_a_i,
  input  logic [XLEN-1:0]         exe_d_i,
  input  logic                    mem_v_i,
  input  logic [dec_pkg::RAW-1:0] mem_a_i,
  input  logic [XLEN-1:0]         mem_d_i,
  input  logic                    wb_v_i,
  input  logic [dec_pkg::RAW-1:0] wb_a_i,
  input  logic [XLEN-1:0]         wb_d_i,
  input  logic                    hz_v_i,
  input  logic [dec_pkg::RAW-1:0] hz_a_i,
  output logic [XLEN-1:0]         val_o,
  output logic                    hz_o
);
  logic nz, exe_hit, mem_hit, wb_hit;

  always_comb begin
    nz      = (src_i != '0);
    exe_hit = nz && exe_v_i && (exe_a_i == src_i);
    mem_hit = nz && mem_v_i && (mem_a_i == src_i);
    wb_hit  = nz && wb_v_i  && (wb_a_i  == src_i);
    hz_o    = nz && hz_v_i  && (hz_a_i  == src_i);
    if (!nz)          val_o = '0;
    else if (exe_hit) val_o = exe_d_i;
    else if (mem_hit) val_o = mem_d_i;
    else if (wb_hit)  val_o = wb_d_i;
    else              val_o = rf_data_i;
  end

  AST_ZERO_REG_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> (val_o == '0 && !hz_o)); // R8
  AST_EXE_BYPASS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_hit && mem_hit) |-> (val_o == exe_d_i)); // R7
  AST_MEM_OVER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (!exe_hit && mem_hit && wb_hit) |-> (val_o == mem_d_i)); // R7
endmodule

// File: rtl/dec_decoder.sv
module dec_decoder #(
  parameter int XLEN = 32
) (
  input  logic [dec_pkg::ILEN-1:0] inst_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [XLEN-1:0]          rs1_i,
  input  logic [XLEN-1:0]          rs2_i,
  output logic                     illegal_o,
  output logic                     wb_en_o,
  output logic [dec_pkg::RAW-1:0]  wb_addr_o,
  output logic [1:0]               wb_sel_o,
  output logic [1:0]               br_kind_o,
  output logic [2:0]               br_cond_o,
  output logic [XLEN-1:0]          br_base_o,
  output logic [XLEN-1:0]          br_off_o,
  output logic [3:0]               alu_op_o,
  output logic [XLEN-1:0]          alu_a_o,
  output logic [XLEN-1:0]          alu_b_o,
  output logic [1:0]               mem_op_o,
  output logic [2:0]               mem_fn_o,
  output logic [2:0]               csr_op_o,
  output logic [11:0]              csr_addr_o
);
  import dec_pkg::*;

  function automatic logic [XLEN-1:0] sext(input logic [31:0] v);
    return XLEN'($signed(v));
  endfunction

  logic [6:0]      opc;
  logic [2:0]      f3;
  logic            f7b5;
  logic [RAW-1:0]  rd;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
  logic            writes;

  always_comb begin
    opc   = inst_i[6:0];
    f3    = inst_i[14:12];
    f7b5  = inst_i[30];
    rd    = inst_i[11:7];
    imm_i = sext({{20{inst_i[31]}}, inst_i[31:20]});
    imm_s = sext({{20{inst_i[31]}}, inst_i[31:25], inst_i[11:7]});
    imm_b = sext({{19{inst_i[31]}}, inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0});
    imm_u = sext({inst_i[31:12], 12'b0});
    imm_j = sext({{11{inst_i[31]}}, inst_i[31], inst_i[19:12], inst_i[20], inst_i[30:21], 1'b0});
  end

  always_comb begin
    illegal_o  = 1'b0;
    writes     = 1'b0;
    wb_sel_o   = WB_ALU;
    br_kind_o  = BR_NONE;
    br_cond_o  = 3'd0;
    br_base_o  = '0;
    br_off_o   = '0;
    alu_op_o   = 4'd0;
    alu_a_o    = rs1_i;
    alu_b_o    = '0;
    mem_op_o   = MEM_NONE;
    mem_fn_o   = 3'd0;
    csr_op_o   = 3'd0;
    csr_addr_o = 12'd0;
    case (opc)
      OPC_LUI: begin
        writes  = 1'b1;
        alu_a_o = '0;
        alu_b_o = imm_u;
      end
      OPC_AUIPC: begin
        writes  = 1'b1;
        alu_a_o = pc_i;
        alu_b_o = imm_u;
      end
      OPC_JAL: begin
        writes    = 1'b1;
        wb_sel_o  = WB_LINK;
        br_kind_o = BR_JAL;
        br_base_o = pc_i;
        br_off_o  = imm_j;
        alu_a_o   = pc_i;
        alu_b_o   = XLEN'(4);
      end
      OPC_JALR: begin
        writes    = 1'b1;
        wb_sel_o  = WB_LINK;
        br_kind_o = BR_JALR;
        br_base_o = rs1_i;
        br_off_o  = imm_i;
        alu_a_o   = pc_i;
        alu_b_o   = XLEN'(4);
      end
      OPC_BRANCH: begin
        br_kind_o = BR_COND;
        br_cond_o = f3;
        br_base_o = pc_i;
        br_off_o  = imm_b;
        alu_b_o   = rs2_i;
      end
      OPC_LOAD: begin
        writes   = 1'b1;
        wb_sel_o = WB_MEM;
        mem_op_o = MEM_LOAD;
        mem_fn_o = f3;
        alu_b_o  = imm_i;
      end
      OPC_STORE: begin
        mem_op_o = MEM_STORE;
        mem_fn_o = f3;
        alu_b_o  = imm_s;
      end
      OPC_OPIMM: begin
        writes   = 1'b1;
        alu_op_o = {(f3 == 3'b101) ? f7b5 : 1'b0, f3};
        alu_b_o  = imm_i;
      end
      OPC_OP: begin
        writes   = 1'b1;
        alu_op_o = {f7b5, f3};
        alu_b_o  = rs2_i;
      end
      OPC_SYSTEM: begin
        if (f3[1:0] != 2'b00) begin
          writes     = 1'b1;
          wb_sel_o   = WB_CSR;
          csr_op_o   = f3;
          csr_addr_o = inst_i[31:20];
        end else begin
          illegal_o = 1'b1;
        end
      end
      default: illegal_o = 1'b1;
    endcase
    wb_en_o   = writes && !illegal_o;
    wb_addr_o = wb_en_o ? rd : '0;
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_pc,
  input  logic [31:0]     in_inst,
  input  logic            redirect_valid,
  input  logic            exe_byp_valid,
  input  logic [4:0]      exe_byp_addr,
  input  logic [XLEN-1:0] exe_byp_data,
  input  logic            mem_byp_valid,
  input  logic [4:0]      mem_byp_addr,
  input  logic [XLEN-1:0] mem_byp_data,
  input  logic            wb_byp_valid,
  input  logic [4:0]      wb_byp_addr,
  input  logic [XLEN-1:0] wb_byp_data,
  input  logic            exe_ldcsr_valid,
  input  logic [4:0]      exe_ldcsr_addr,
  output logic [4:0]      rf_raddr1,
  output logic [4:0]      rf_raddr2,
  input  logic [XLEN-1:0] rf_rdata1,
  input  logic [XLEN-1:0] rf_rdata2,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_pc,
  output logic [31:0]     out_inst,
  output logic            out_illegal,
  output logic            out_wb_en,
  output logic [4:0]      out_wb_addr,
  output logic [1:0]      out_wb_sel,
  output logic [1:0]      out_br_kind,
  output logic [2:0]      out_br_cond,
  output logic [XLEN-1:0] out_br_base,
  output logic [XLEN-1:0] out_br_off,
  output logic [3:0]      out_alu_op,
  output logic [XLEN-1:0] out_alu_a,
  output logic [XLEN-1:0] out_alu_b,
  output logic [1:0]      out_mem_op,
  output logic [2:0]      out_mem_fn,
  output logic [2:0]      out_csr_op,
  output logic [11:0]     out_csr_addr,
  output logic [XLEN-1:0] out_rs1_val,
  output logic [XLEN-1:0] out_rs2_val
);
  import dec_pkg::*;

  localparam int NSRC = 2;

  logic            held_v, stall, take;
  logic [XLEN-1:0] held_pc;
  logic [ILEN-1:0] held_inst;
  logic [RAW-1:0]  src   [NSRC];
  logic [XLEN-1:0] rfd   [NSRC];
  logic [XLEN-1:0] sval  [NSRC];
  logic [NSRC-1:0] hz_hit;

  dec_inreg #(.XLEN(XLEN)) i_inreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pc    (in_pc),
    .in_inst  (in_inst),
    .flush_i  (redirect_valid),
    .take_i   (take),
    .valid_o  (held_v),
    .pc_o     (held_pc),
    .inst_o   (held_inst)
  );

  assign src[0] = held_inst[19:15];
  assign src[1] = held_inst[24:20];
  assign rfd[0] = rf_rdata1;
  assign rfd[1] = rf_rdata2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    dec_operand #(.XLEN(XLEN)) i_operand (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src[g]),
      .rf_data_i (rfd[g]),
      .exe_v_i   (exe_byp_valid),
      .exe_a_i   (exe_byp_addr),
      .exe_d_i   (exe_byp_data),
      .mem_v_i   (mem_byp_valid),
      .mem_a_i   (mem_byp_addr),
      .mem_d_i   (mem_byp_data),
      .wb_v_i    (wb_byp_valid),
      .wb_a_i    (wb_byp_addr),
      .wb_d_i    (wb_byp_data),
      .hz_v_i    (exe_ldcsr_valid),
      .hz_a_i    (exe_ldcsr_addr),
      .val_o     (sval[g]),
      .hz_o      (hz_hit[g])
    );
  end

  dec_decoder #(.XLEN(XLEN)) i_decoder (
    .inst_i     (held_inst),
    .pc_i       (held_pc),
    .rs1_i      (sval[0]),
    .rs2_i      (sval[1]),
    .illegal_o  (out_illegal),
    .wb_en_o    (out_wb_en),
    .wb_addr_o  (out_wb_addr),
    .wb_sel_o   (out_wb_sel),
    .br_kind_o  (out_br_kind),
    .br_cond_o  (out_br_cond),
    .br_base_o  (out_br_base),
    .br_off_o   (out_br_off),
    .alu_op_o   (out_alu_op),
    .alu_a_o    (out_alu_a),
    .alu_b_o    (out_alu_b),
    .mem_op_o   (out_mem_op),
    .mem_fn_o   (out_mem_fn),
    .csr_op_o   (out_csr_op),
    .csr_addr_o (out_csr_addr)
  );

  always_comb begin
    stall     = held_v && (|hz_hit);
    out_valid = held_v && !stall && !redirect_valid;
    take      = out_valid && out_ready;
  end

  assign rf_raddr1   = src[0];
  assign rf_raddr2   = src[1];
  assign out_pc      = held_pc;
  assign out_inst    = held_inst;
  assign out_rs1_val = sval[0];
  assign out_rs2_val = sval[1];

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect_valid) |=> (held_v && $stable(out_pc) && $stable(out_inst))); // R3
  AST_STALL_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect_valid) |=> (held_v && $stable(rf_raddr1) && $stable(rf_raddr2) && $stable(out_pc))); // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect_valid) |-> !in_ready); // R9
  AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !out_valid); // R10
  AST_STALL_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && redirect_valid) |=> !held_v); // R11
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_wb_en); // R5
endmodule

// File: tb/test_dec_stage.sv
`timescale 1ns/1ps
module test_dec_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, redirect_valid;
  logic [31:0] in_pc, in_inst;
  logic        exe_byp_valid, mem_byp_valid, wb_byp_valid, exe_ldcsr_valid;
  logic [4:0]  exe_byp_addr, mem_byp_addr, wb_byp_addr, exe_ldcsr_addr;
  logic [31:0] exe_byp_data, mem_byp_data, wb_byp_data;
  logic [4:0]  rf_raddr1, rf_raddr2;
  logic [31:0] rf_rdata1, rf_rdata2;
  logic        out_valid, out_ready, out_illegal, out_wb_en;
  logic [31:0] out_pc, out_inst, out_br_base, out_br_off, out_alu_a, out_alu_b;
  logic [31:0] out_rs1_val, out_rs2_val;
  logic [4:0]  out_wb_addr;
  logic [1:0]  out_wb_sel, out_br_kind, out_mem_op;
  logic [2:0]  out_br_cond, out_mem_fn, out_csr_op;
  logic [3:0]  out_alu_op;
  logic [11:0] out_csr_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dec_stage #(.XLEN(32)) i_dec_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_inst(in_inst), .redirect_valid(redirect_valid),
    .exe_byp_valid(exe_byp_valid), .exe_byp_addr(exe_byp_addr), .exe_byp_data(exe_byp_data),
    .mem_byp_valid(mem_byp_valid), .mem_byp_addr(mem_byp_addr), .mem_byp_data(mem_byp_data),
    .wb_byp_valid(wb_byp_valid), .wb_byp_addr(wb_byp_addr), .wb_byp_data(wb_byp_data),
    .exe_ldcsr_valid(exe_ldcsr_valid), .exe_ldcsr_addr(exe_ldcsr_addr),
    .rf_raddr1(rf_raddr1), .rf_raddr2(rf_raddr2), .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_inst(out_inst),
    .out_illegal(out_illegal), .out_wb_en(out_wb_en), .out_wb_addr(out_wb_addr),
    .out_wb_sel(out_wb_sel), .out_br_kind(out_br_kind), .out_br_cond(out_br_cond),
    .out_br_base(out_br_base), .out_br_off(out_br_off), .out_alu_op(out_alu_op),
    .out_alu_a(out_alu_a), .out_alu_b(out_alu_b), .out_mem_op(out_mem_op),
    .out_mem_fn(out_mem_fn), .out_csr_op(out_csr_op), .out_csr_addr(out_csr_addr),
    .out_rs1_val(out_rs1_val), .out_rs2_val(out_rs2_val)
  );

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
      input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] pc, input logic [31:0] inst);
    @(negedge clk);
    in_valid = 1'b1;
    in_pc    = pc;
    in_inst  = inst;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_alu_ops();
    rf_rdata1 = 32'd5; rf_rdata2 = 32'd7;
    push(32'h100, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    #1;
    chk("R2", "valid after accept", {31'd0, out_valid}, 32'd1);
    chk("R2", "pc", out_pc, 32'h100);
    chk("R2", "raddr1", {27'd0, rf_raddr1}, 32'd1);
    chk("R2", "raddr2", {27'd0, rf_raddr2}, 32'd2);
    chk("R4", "wb_en", {31'd0, out_wb_en}, 32'd1);
    chk("R4", "wb_addr", {27'd0, out_wb_addr}, 32'd3);
    chk("R4", "wb_sel", {30'd0, out_wb_sel}, 32'd0);
    chk("R6", "alu_a", out_alu_a, 32'd5);
    chk("R6", "alu_b", out_alu_b, 32'd7);
    drain();
    push(32'h104, enc_r(7'h20, 5'd2, 5'd1, 3'd0, 5'd3));
    #1;
    chk("R4", "sub alu_op", {28'd0, out_alu_op}, 32'd8);
    drain();
    rf_rdata1 = 32'd10;
    push(32'h108, enc_i(12'hFFD, 5'd1, 3'd0, 5'd5, 7'b0010011));
    #1;
    chk("R6", "addi alu_a", out_alu_a, 32'd10);
    chk("R6", "addi imm", out_alu_b, 32'hFFFF_FFFD);
    drain();
    push(32'h10C, {20'hABCDE, 5'd7, 7'b0110111});
    #1;
    chk("R6", "lui alu_a", out_alu_a, 32'd0);
    chk("R6", "lui alu_b", out_alu_b, 32'hABCD_E000);
    drain();
  endtask

  task automatic t_control_flow();
    push(32'h200, enc_b(13'h1FF8, 5'd2, 5'd1, 3'd1));
    #1;
    chk("R6", "bne kind", {30'd0, out_br_kind}, 32'd3);
    chk("R6", "bne cond", {29'd0, out_br_cond}, 32'd1);
    chk("R6", "bne base", out_br_base, 32'h200);
    chk("R6", "bne off", out_br_off, 32'hFFFF_FFF8);
    chk("R4", "branch wb_en", {31'd0, out_wb_en}, 32'd0);
    drain();
    rf_rdata1 = 32'h2000;
    push(32'h204, enc_i(12'd16, 5'd2, 3'd0, 5'd1, 7'b1100111));
    #1;
    chk("R6", "jalr kind", {30'd0, out_br_kind}, 32'd2);
    chk("R6", "jalr base", out_br_base, 32'h2000);
    chk("R6", "jalr off", out_br_off, 32'd16);
    chk("R4", "jalr wb_sel", {30'd0, out_wb_sel}, 32'd3);
    drain();
    push(32'h208, enc_j(21'h000800, 5'd1));
    #1;
    chk("R6", "jal kind", {30'd0, out_br_kind}, 32'd1);
    chk("R6", "jal base", out_br_base, 32'h208);
    chk("R6", "jal off", out_br_off, 32'h800);
    drain();
  endtask

  task automatic t_mem_csr();
    rf_rdata1 = 32'h40; rf_rdata2 = 32'h99;
    push(32'h300, enc_i(12'd8, 5'd1, 3'd2, 5'd4, 7'b0000011));
    #1;
    chk("R4", "load mem_op", {30'd0, out_mem_op}, 32'd1);
    chk("R4", "load mem_fn", {29'd0, out_mem_fn}, 32'd2);
    chk("R4", "load wb_sel", {30'd0, out_wb_sel}, 32'd1);
    chk("R6", "load alu_b", out_alu_b, 32'd8);
    drain();
    push(32'h304, enc_s(12'hFFC, 5'd2, 5'd1, 3'd2));
    #1;
    chk("R4", "store mem_op", {30'd0, out_mem_op}, 32'd2);
    chk("R4", "store wb_en", {31'd0, out_wb_en}, 32'd0);
    chk("R6", "store alu_b", out_alu_b, 32'hFFFF_FFFC);
    chk("R6", "store data", out_rs2_val, 32'h99);
    drain();
    push(32'h308, enc_i(12'h300, 5'd1, 3'd2, 5'd6, 7'b1110011));
    #1;
    chk("R4", "csr op", {29'd0, out_csr_op}, 32'd2);
    chk("R4", "csr addr", {20'd0, out_csr_addr}, 32'h300);
    chk("R4", "csr wb_sel", {30'd0, out_wb_sel}, 32'd2);
    chk("R5", "csr legal", {31'd0, out_illegal}, 32'd0);
    drain();
  endtask

  task automatic t_illegal();
    push(32'h400, 32'h0000_0073);
    #1;
    chk("R5", "ecall valid", {31'd0, out_valid}, 32'd1);
    chk("R5", "ecall illegal", {31'd0, out_illegal}, 32'd1);
    chk("R5", "ecall wb_en", {31'd0, out_wb_en}, 32'd0);
    drain();
    push(32'h404, 32'h0000_01FF);
    #1;
    chk("R5", "bad opcode illegal", {31'd0, out_illegal}, 32'd1);
    chk("R5", "bad opcode wb_en", {31'd0, out_wb_en}, 32'd0);
    drain();
  endtask

  task automatic t_bypass();
    rf_rdata1 = 32'd1; rf_rdata2 = 32'd2;
    out_ready = 1'b0;
    push(32'h500, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    exe_byp_valid = 1'b1; exe_byp_addr = 5'd1; exe_byp_data = 32'd100;
    mem_byp_valid = 1'b1; mem_byp_addr = 5'd1; mem_byp_data = 32'd200;
    wb_byp_valid  = 1'b1; wb_byp_addr  = 5'd2; wb_byp_data  = 32'd400;
    #1;
    chk("R7", "exe beats mem", out_rs1_val, 32'd100);
    chk("R7", "wb over rf", out_rs2_val, 32'd400);
    mem_byp_addr = 5'd2; mem_byp_data = 32'd300;
    #1;
    chk("R7", "mem beats wb", out_rs2_val, 32'd300);
    exe_byp_valid = 1'b0;
    #1;
    chk("R7", "rf when no hit", out_rs1_val, 32'd1);
    mem_byp_valid = 1'b0; wb_byp_valid = 1'b0;
    #1;
    chk("R7", "rf second source", out_rs2_val, 32'd2);
    drain();
  endtask

  task automatic t_zero_reg();
    rf_rdata1 = 32'd9; rf_rdata2 = 32'd9;
    push(32'h600, enc_r(7'h00, 5'd0, 5'd0, 3'd0, 5'd3));
    exe_byp_valid = 1'b1; exe_byp_addr = 5'd0; exe_byp_data = 32'd55;
    exe_ldcsr_valid = 1'b1; exe_ldcsr_addr = 5'd0;
    #1;
    chk("R8", "x0 first", out_rs1_val, 32'd0);
    chk("R8", "x0 second", out_rs2_val, 32'd0);
    chk("R8", "x0 no stall", {31'd0, out_valid}, 32'd1);
    exe_byp_valid = 1'b0; exe_ldcsr_valid = 1'b0;
    drain();
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    push(32'h700, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    #1;
    chk("R2", "full not ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    #1;
    chk("R3", "held valid", {31'd0, out_valid}, 32'd1);
    chk("R3", "held pc", out_pc, 32'h700);
    out_ready = 1'b1;
    in_valid = 1'b1; in_pc = 32'h704; in_inst = enc_r(7'h00, 5'd5, 5'd4, 3'd0, 5'd6);
    #1;
    chk("R2", "ready as entry leaves", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R2", "next entry pc", out_pc, 32'h704);
    chk("R2", "next entry valid", {31'd0, out_valid}, 32'd1);
    drain();
  endtask

  task automatic t_stall();
    push(32'h800, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    exe_ldcsr_valid = 1'b1; exe_ldcsr_addr = 5'd2;
    #1;
    chk("R9", "stall on rs2 valid", {31'd0, out_valid}, 32'd0);
    chk("R9", "stall ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    exe_ldcsr_addr = 5'd1;
    #1;
    chk("R9", "stall on rs1 valid", {31'd0, out_valid}, 32'd0);
    chk("R9", "stall pc stable", out_pc, 32'h800);
    chk("R9", "stall raddr2 stable", {27'd0, rf_raddr2}, 32'd2);
    exe_ldcsr_addr = 5'd9;
    #1;
    chk("R9", "unrelated dest", {31'd0, out_valid}, 32'd1);
    exe_ldcsr_valid = 1'b0;
    drain();
  endtask

  task automatic t_redirect();
    out_ready = 1'b0;
    push(32'h900, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    redirect_valid = 1'b1;
    in_valid = 1'b1; in_pc = 32'h904; in_inst = enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3);
    #1;
    chk("R10", "valid during redirect", {31'd0, out_valid}, 32'd0);
    chk("R10", "ready during redirect", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    redirect_valid = 1'b0; in_valid = 1'b0;
    #1;
    chk("R10", "empty after redirect", {31'd0, out_valid}, 32'd0);
    chk("R10", "ready after redirect", {31'd0, in_ready}, 32'd1);
    out_ready = 1'b1;
  endtask

  task automatic t_redirect_in_stall();
    push(32'hA00, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    exe_ldcsr_valid = 1'b1; exe_ldcsr_addr = 5'd1;
    @(negedge clk);
    redirect_valid = 1'b1;
    @(negedge clk);
    redirect_valid = 1'b0;
    exe_ldcsr_valid = 1'b0;
    #1;
    chk("R11", "no output after cleared hazard", {31'd0, out_valid}, 32'd0);
    chk("R11", "ready after flush", {31'd0, in_ready}, 32'd1);
    push(32'hA04, enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3));
    #1;
    chk("R11", "new entry flows", out_pc, 32'hA04);
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_pc = '0; in_inst = '0; redirect_valid = 1'b0;
    exe_byp_valid = 1'b0; exe_byp_addr = '0; exe_byp_data = '0;
    mem_byp_valid = 1'b0; mem_byp_addr = '0; mem_byp_data = '0;
    wb_byp_valid = 1'b0; wb_byp_addr = '0; wb_byp_data = '0;
    exe_ldcsr_valid = 1'b0; exe_ldcsr_addr = '0;
    rf_rdata1 = '0; rf_rdata2 = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_alu_ops();
    t_control_flow();
    t_mem_csr();
    t_illegal();
    t_bypass();
    t_zero_reg();
    t_backpressure();
    t_stall();
    t_redirect();
    t_redirect_in_stall();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule